// File: doc/BRIEF.md
# Half-Rate Bus Mode Controller

This block decides when a front-side bus interface drives and samples its signals. The bus can run at full rate, or at half rate relative to the bus clock. Software or a power manager asks for a mode with a one-cycle request pulse that carries the target mode. The controller waits for the bus to be transaction-idle, switches mode, and reports completion with a one-cycle acknowledge. A switch, once started, cannot be cancelled.

The block takes raw single-cycle control enables and strobe enables. Its control outputs are registered. In half rate each control is stretched over two bus clocks. The strobe outputs report how many transitions per bus clock a double-pumped strobe and a quad-pumped strobe must make. A sample-enable output marks the bus clocks on which inputs are captured.

The sequencer has four states:
- `ST_FULL`: full rate, stable.
- `ST_DN_WAIT`: a down-shift has been accepted and the block is waiting for idle.
- `ST_HALF`: half rate, stable.
- `ST_UP_WAIT`: an up-shift has been accepted and the block is waiting for idle.

Its transitions are:
- **accept-down** (`ST_FULL`→`ST_DN_WAIT`): a request for half rate arrives after the holdoff has elapsed.
- **enter-half** (`ST_DN_WAIT`→`ST_HALF`): the bus is idle.
- **accept-up** (`ST_HALF`→`ST_UP_WAIT`): a request for full rate arrives.
- **enter-full** (`ST_UP_WAIT`→`ST_FULL`): the bus is idle.

Top module: `hrb_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, `half_mode`, `busy` and `ack` are 0, `sample_en` is 1, and `ctl_out`, `dstb_edges` and `qstb_edges` are 0.
- R2: A request for half rate (`req_vld`=1, `req_half`=1) seen in `ST_FULL` before HOLDOFF clock edges have passed since reset release is discarded, and the mode stays full.
- R3: In full rate, `ctl_out` equals the `ctl_in` value of the previous cycle, and `sample_en` is 1 on every cycle.
- R4: In half rate, `sample_en` is 1 on the first half-rate cycle and then on every second cycle; it is 0 on the others.
- R5: In half rate, `ctl_in` is captured only on cycles with `sample_en`=1, and each captured value stays on `ctl_out` for two cycles.
- R6: `dstb_edges` gives the double-pumped strobe transitions per clock for the enable captured on the last sample cycle: 2 in full rate, 1 in half rate, 0 when the strobe is disabled.
- R7: `qstb_edges` gives the quad-pumped strobe transitions per clock, captured the same way: 4 in full rate, 2 in half rate, 0 when the strobe is disabled.
- R8: An accepted request sets `busy`=1. The mode changes only on the edge where `bus_idle`=1. Until that edge, `busy` stays 1 and the mode does not change, whatever requests arrive.
- R9: `ack` is 1 for exactly one cycle, the first cycle in the new mode, and `busy` is 0 in that cycle.
- R10: A request that arrives while `busy`=1 is stored, with the latest one winning. It is acted on in the cycle after the switch completes.
- R11: A request for the mode that is already active is ignored: `busy` stays 0 and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | One-cycle mode request pulse |
| req_half | input | 1 | Target mode of the request: 1 = half rate, 0 = full rate |
| bus_idle | input | 1 | Bus has no transaction in flight |
| ctl_in | input | NCTL | Raw single-cycle common-clock control enables |
| dstb_en | input | 1 | Double-pumped strobe active this cycle |
| qstb_en | input | 1 | Quad-pumped strobe active this cycle |
| half_mode | output | 1 | Half rate is in effect |
| busy | output | 1 | A mode switch is pending |
| ack | output | 1 | Switch-complete pulse |
| sample_en | output | 1 | Inputs are captured on this clock |
| ctl_out | output | NCTL | Stretched control outputs |
| dstb_edges | output | 2 | Double-pumped strobe transitions per clock |
| qstb_edges | output | 3 | Quad-pumped strobe transitions per clock |

## Verification
The bench sends a half-rate request a few cycles after reset. A design that ignored the holdoff would shift down at once.

It holds `bus_idle` low while a request for the opposite mode arrives. A design that allowed aborts would fall back to the old mode. A design without the stored request would stay in half rate after the first switch completed.

Random traffic puts the switch edges on both phases, and a second reset is applied while the block is in half rate. These catch a phase that is not cleared on entry, controls that are held for one cycle or three, and strobe counts taken from the wrong mode.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

    typedef enum logic [1:0] {
        ST_FULL    = 2'd0,
        ST_DN_WAIT = 2'd1,
        ST_HALF    = 2'd2,
        ST_UP_WAIT = 2'd3
    } hrb_state_e;

    localparam int DSTB_W = 2;
    localparam int QSTB_W = 3;

    localparam logic [DSTB_W-1:0] DSTB_FULL = 2'd2;
    localparam logic [DSTB_W-1:0] DSTB_HALF = 2'd1;
    localparam logic [QSTB_W-1:0] QSTB_FULL = 3'd4;
    localparam logic [QSTB_W-1:0] QSTB_HALF = 3'd2;

endpackage

// File: rtl/hrb_holdoff.sv
module hrb_holdoff #(
    parameter int HOLDOFF = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLDOFF);

    logic [CNT_W-1:0] cnt_q;

    // Counts clock edges since reset release and stops at LIMIT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/hrb_seq.sv
module hrb_seq
    import hrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_vld,
    input  logic       req_half,
    input  logic       bus_idle,
    input  logic       holdoff_done,
    output hrb_state_e state,
    output logic       busy,
    output logic       half_mode,
    output logic       ack
);
    hrb_state_e state_q;
    hrb_state_e state_d;
    logic       pend_v_q;
    logic       pend_t_q;
    logic       pend_v_d;
    logic       pend_t_d;
    logic       eff_v;
    logic       eff_t;
    logic       in_wait;

    // A new pulse overrides the stored request.
    assign eff_v   = req_vld | pend_v_q;
    assign eff_t   = req_vld ? req_half : pend_t_q;
    assign in_wait = (state_q == ST_DN_WAIT) || (state_q == ST_UP_WAIT);

    always_comb begin
        state_d  = state_q;
        pend_v_d = pend_v_q;
        pend_t_d = pend_t_q;
        unique case (state_q)
            ST_FULL: begin
                // accept-down; an early or same-mode request is dropped
                if (eff_v && eff_t && holdoff_done) begin
                    state_d = ST_DN_WAIT;
                end
                pend_v_d = 1'b0;
            end
            ST_DN_WAIT: begin
                if (req_vld) begin
                    pend_v_d = 1'b1;
                    pend_t_d = req_half;
                end
                // enter-half
                if (bus_idle) begin
                    state_d = ST_HALF;
                end
            end
            ST_HALF: begin
                // accept-up
                if (eff_v && !eff_t) begin
                    state_d = ST_UP_WAIT;
                end
                pend_v_d = 1'b0;
            end
            ST_UP_WAIT: begin
                if (req_vld) begin
                    pend_v_d = 1'b1;
                    pend_t_d = req_half;
                end
                // enter-full
                if (bus_idle) begin
                    state_d = ST_FULL;
                end
            end
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_FULL;
            pend_v_q <= 1'b0;
            pend_t_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            pend_v_q <= pend_v_d;
            pend_t_q <= pend_t_d;
        end
    end

    // Output process: the completion pulse lands in the first cycle of the new mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else begin
            ack <= in_wait && bus_idle;
        end
    end

    assign state     = state_q;
    assign busy      = in_wait;
    assign half_mode = (state_q == ST_HALF) || (state_q == ST_UP_WAIT);
endmodule

// File: rtl/hrb_phase.sv
module hrb_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic half_mode,
    output logic phase,
    output logic sample_en
);
    logic phase_q;

    // The phase is held at 0 outside half rate, so it is 0 on the first half-rate cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= half_mode ? ~phase_q : 1'b0;
        end
    end

    assign phase     = phase_q;
    assign sample_en = ~half_mode | ~phase_q;
endmodule

// File: rtl/hrb_lane.sv
module hrb_lane #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (cap) begin
            q_r <= d;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/hrb_ctrl.sv
module hrb_ctrl
    import hrb_pkg::*;
#(
    parameter int NCTL    = 4,
    parameter int HOLDOFF = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_half,
    input  logic              bus_idle,
    input  logic [NCTL-1:0]   ctl_in,
    input  logic              dstb_en,
    input  logic              qstb_en,
    output logic              half_mode,
    output logic              busy,
    output logic              ack,
    output logic              sample_en,
    output logic [NCTL-1:0]   ctl_out,
    output logic [DSTB_W-1:0] dstb_edges,
    output logic [QSTB_W-1:0] qstb_edges
);
    hrb_state_e        state;
    logic              holdoff_done;
    logic              phase;
    logic [DSTB_W-1:0] dstb_code;
    logic [QSTB_W-1:0] qstb_code;

    hrb_holdoff #(.HOLDOFF(HOLDOFF)) i_holdoff (
        .clk  (clk),
        .rst_n(rst_n),
        .done (holdoff_done)
    );

    hrb_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vld     (req_vld),
        .req_half    (req_half),
        .bus_idle    (bus_idle),
        .holdoff_done(holdoff_done),
        .state       (state),
        .busy        (busy),
        .half_mode   (half_mode),
        .ack         (ack)
    );

    hrb_phase i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_mode(half_mode),
        .phase    (phase),
        .sample_en(sample_en)
    );

    // One capture lane per control bit.
    for (genvar g = 0; g < NCTL; g++) begin : g_ctl
        hrb_lane #(.W(1)) i_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .cap  (sample_en),
            .d    (ctl_in[g]),
            .q    (ctl_out[g])
        );
    end

    // The transition count comes from the mode in force when the enable is captured.
    always_comb begin
        dstb_code = '0;
        qstb_code = '0;
        if (dstb_en) begin
            dstb_code = half_mode ? DSTB_HALF : DSTB_FULL;
        end
        if (qstb_en) begin
            qstb_code = half_mode ? QSTB_HALF : QSTB_FULL;
        end
    end

    hrb_lane #(.W(DSTB_W)) i_dstb (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (sample_en),
        .d    (dstb_code),
        .q    (dstb_edges)
    );

    hrb_lane #(.W(QSTB_W)) i_qstb (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (sample_en),
        .d    (qstb_code),
        .q    (qstb_edges)
    );
endmodule

// File: rtl/hrb_chk.sv
module hrb_chk #(
    parameter int NCTL = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_idle,
    input logic            holdoff_done,
    input logic            half_mode,
    input logic            busy,
    input logic            ack,
    input logic            sample_en,
    input logic [NCTL-1:0] ctl_out,
    input logic [1:0]      dstb_edges,
    input logic [2:0]      qstb_edges
);
    // R2
    early_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !holdoff_done |-> (!half_mode && !busy));

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_idle) |=> (busy && $stable(half_mode)));

    // R5
    stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && !sample_en) |=> $stable(ctl_out));

    // R4
    alt_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && $past(half_mode)) |-> (sample_en != $past(sample_en)));

    // R9
    ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(busy) && !busy));

    // R6
    dstb_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && sample_en) |=> (dstb_edges != 2'd2 && dstb_edges != 2'd3));

    // R7
    qstb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qstb_edges == 3'd0 || qstb_edges == 3'd2 || qstb_edges == 3'd4));
endmodule

bind hrb_ctrl hrb_chk #(.NCTL(NCTL)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_idle    (bus_idle),
    .holdoff_done(holdoff_done),
    .half_mode   (half_mode),
    .busy        (busy),
    .ack         (ack),
    .sample_en   (sample_en),
    .ctl_out     (ctl_out),
    .dstb_edges  (dstb_edges),
    .qstb_edges  (qstb_edges)
);

// File: tb/test_hrb_ctrl.sv
module test_hrb_ctrl;
    localparam int NCTL = 4;
    localparam int HOLD = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld = 1'b0;
    logic            req_half = 1'b0;
    logic            bus_idle = 1'b0;
    logic [NCTL-1:0] ctl_in = '0;
    logic            dstb_en = 1'b0;
    logic            qstb_en = 1'b0;
    logic            half_mode;
    logic            busy;
    logic            ack;
    logic            sample_en;
    logic [NCTL-1:0] ctl_out;
    logic [1:0]      dstb_edges;
    logic [2:0]      qstb_edges;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done_flag = 1'b0;

    // Reference model. States: 0 full, 1 down-wait, 2 half, 3 up-wait.
    int m_st = 0;
    int m_cnt = 0;
    int m_d = 0;
    int m_q = 0;
    bit m_ph = 1'b0;
    bit m_pv = 1'b0;
    bit m_pt = 1'b0;
    bit m_ack = 1'b0;
    logic [NCTL-1:0] m_ctl = '0;

    always #4 clk = ~clk;

    hrb_ctrl #(.NCTL(NCTL), .HOLDOFF(HOLD)) i_hrb_ctrl (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_half(req_half),
        .bus_idle(bus_idle), .ctl_in(ctl_in), .dstb_en(dstb_en), .qstb_en(qstb_en),
        .half_mode(half_mode), .busy(busy), .ack(ack), .sample_en(sample_en),
        .ctl_out(ctl_out), .dstb_edges(dstb_edges), .qstb_edges(qstb_edges)
    );

    function automatic bit mdl_half(input int st);
        return (st == 2) || (st == 3);
    endfunction

    function automatic bit mdl_busy(input int st);
        return (st == 1) || (st == 3);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_d = 0; m_q = 0; m_ph = 0;
            m_pv = 0; m_pt = 0; m_ack = 0; m_ctl = '0;
        end else begin
            bit hn, se, dn, ev, et;
            hn = mdl_half(m_st);
            se = !hn || !m_ph;
            dn = (m_cnt >= HOLD);
            if (se) begin
                m_ctl = ctl_in;
                m_d = dstb_en ? (hn ? 1 : 2) : 0;
                m_q = qstb_en ? (hn ? 2 : 4) : 0;
            end
            m_ack = mdl_busy(m_st) && bus_idle;
            m_ph = hn ? !m_ph : 1'b0;
            ev = req_vld || m_pv;
            et = req_vld ? req_half : m_pt;
            case (m_st)
                0: begin if (ev && et && dn) m_st = 1; m_pv = 0; end
                1: begin if (req_vld) begin m_pv = 1; m_pt = req_half; end
                         if (bus_idle) m_st = 2; end
                2: begin if (ev && !et) m_st = 3; m_pv = 0; end
                default: begin if (req_vld) begin m_pv = 1; m_pt = req_half; end
                         if (bus_idle) m_st = 0; end
            endcase
            if (m_cnt < HOLD) m_cnt++;
        end
    end

    // Every-cycle comparison, between clock edges.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            bit hn;
            hn = mdl_half(m_st);
            check("R8 half_mode", half_mode, hn);
            check("R8 busy", busy, mdl_busy(m_st));
            check("R9 ack", ack, m_ack);
            check("R4 sample_en", sample_en, !hn || !m_ph);
            check(hn ? "R5 ctl_out" : "R3 ctl_out", ctl_out, m_ctl);
            check("R6 dstb_edges", dstb_edges, m_d);
            check("R7 qstb_edges", qstb_edges, m_q);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input bit tgt);
        req_vld = 1'b1; req_half = tgt;
        step(1);
        req_vld = 1'b0;
    endtask

    task automatic check_reset_state();
        check("R1 half_mode", half_mode, 0);
        check("R1 busy", busy, 0);
        check("R1 ack", ack, 0);
        check("R1 sample_en", sample_en, 1);
        check("R1 ctl_out", ctl_out, 0);
        check("R1 dstb_edges", dstb_edges, 0);
        check("R1 qstb_edges", qstb_edges, 0);
    endtask

    initial begin
        process::self().srandom(32'd5150);
        step(3);
        check_reset_state();
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(1);
        check_reset_state();

        // R2: early down-shift request is discarded
        bus_idle = 1'b1;
        pulse_req(1'b1);
        step(3);
        check("R2 stays full", half_mode, 0);
        check("R2 not busy", busy, 0);

        // R11: request for the current mode is ignored
        pulse_req(1'b0);
        check("R11 busy", busy, 0);
        check("R11 mode", half_mode, 0);
        step(HOLD);

        // R8/R10: accept down, conflicting request during wait is stored
        bus_idle = 1'b0;
        pulse_req(1'b1);
        check("R8 busy after accept", busy, 1);
        pulse_req(1'b0);
        step(4);
        check("R8 no abort", busy, 1);
        check("R8 mode held", half_mode, 0);
        bus_idle = 1'b1;
        step(1);
        check("R9 ack on entry", ack, 1);
        check("R8 entered half", half_mode, 1);
        bus_idle = 1'b0;
        step(1);
        check("R10 stored request served", busy, 1);
        check("R10 still half while waiting", half_mode, 1);
        bus_idle = 1'b1;
        step(1);
        check("R10 back to full", half_mode, 0);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            req_vld  = ($urandom_range(0, 5) == 0);
            req_half = $urandom_range(0, 1);
            bus_idle = ($urandom_range(0, 2) != 0);
            ctl_in   = NCTL'($urandom);
            dstb_en  = $urandom_range(0, 1);
            qstb_en  = $urandom_range(0, 1);
            step(1);
        end

        // R1: reset taken while in half rate
        req_vld = 1'b0; bus_idle = 1'b1; ctl_in = '1; dstb_en = 1; qstb_en = 1;
        step(HOLD + 2);
        pulse_req(1'b1);
        step(2);
        check("R1 setup reached half", half_mode, 1);
        cmp_on = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        ctl_in = '0; dstb_en = 0; qstb_en = 0;
        step(1);
        check_reset_state();
        cmp_on = 1'b1;
        pulse_req(1'b1);
        step(1);
        check("R2 second reset holdoff", half_mode, 0);
        step(5);
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule